// File: doc/BRIEF.md
# Jump Target Trace Buffer

This debug block watches the stream of committed program-counter values from a 32-bit processor and keeps a circular history of the fetch addresses that broke sequential flow: taken branches, jumps and exception entries. A valid PC counts as a break when it is not equal to the previous valid PC plus four. Each break is written into a ring of entries. A debugger reads the ring either by stepping through it, oldest entry first, or by asking for an index counted from the oldest entry.

A second path compares a live copy of the architectural registers with a shadow copy held inside the block. The live copy holds the 32 general registers, the two multiply/divide result registers and the exception return address. When a register differs from its shadow value, the block sends out a change record. The record holds the most recent valid PC, the register index and the new value, and the shadow value is then updated. Change records leave through a valid/ready handshake. While the consumer is not ready, the scan halts and no record is lost.

Top module: `jtt_top`

## Requirements
- R1: After a synchronous active-low reset, every ring entry reads 0xFFFFFFFF, the write pointer is 0, the step cursor points at the oldest entry, every shadow register is 0 and `chg_valid` is low.
- R2: A valid PC is written to the ring only when it differs from the previous valid PC plus 4. The previous-PC register resets to 0, so a first PC of 0x4 is not recorded.
- R3: The previous-PC register takes every valid PC, whether or not that PC was recorded.
- R4: Each recording advances the write pointer by one, modulo the depth (32). Once more than 32 breaks have been recorded, the oldest ones are overwritten.
- R5: A read with `rd_random`=0 returns the entry at (oldest + cursor) and then moves the cursor up by one, modulo the depth. A read that has `rd_restart` high reads offset 0 and leaves the cursor at 1. `rd_data` and a one-cycle `rd_valid` pulse appear one clock after `rd_en`.
- R6: A read with `rd_random`=1 returns the entry at `rd_index` counted from the oldest entry. Index 0 is the oldest entry and index 31 is the newest.
- R7: A recording and a read in the same cycle are allowed. The read returns the contents and uses the write pointer from before that write.
- R8: Register index 0–31 are the general registers, 32 is HI, 33 is LO and 34 is EPC. A live value that differs from its shadow value gives exactly one record, carrying the most recent valid PC, the index and the new value. Registers that do not change give no record.
- R9: While `chg_valid` is high and `chg_ready` is low, the record stays stable and the scan halts. A change found later is sent after the held record, in scan order.
- R10: The scan looks at one register per clock and wraps from the last index to 0. With `chg_ready` high, a single change is reported within NREGS+2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_valid | input | 1 | Committed PC strobe |
| pc_value | input | 32 | Committed PC |
| rd_en | input | 1 | Read request |
| rd_random | input | 1 | 1: indexed read, 0: stepped read |
| rd_restart | input | 1 | Return the step cursor to the oldest entry |
| rd_index | input | AW (5) | Index from the oldest entry, used for indexed reads |
| rd_data | output | 32 | Entry that was read |
| rd_valid | output | 1 | `rd_data` valid, one clock after `rd_en` |
| regs_live | input | NREGS*32 (1120) | Live register values, index i at bits [32i+31:32i] |
| chg_valid | output | 1 | Change record valid |
| chg_ready | input | 1 | Consumer accepts the record |
| chg_pc | output | 32 | Most recent valid PC when the change was found |
| chg_idx | output | IW (6) | Register index |
| chg_value | output | 32 | New register value |

## Verification
The bench sends a sequential run right after an earlier jump. A comparator that skipped the previous-PC update on sequential fetches would then record 0x108 after 0x104. It also sends a first PC of 0x4, which a comparator that ignored the reset value of the previous PC would record. It writes more than 32 breaks and checks that indexed reads start at the ninth break, which catches a readout based on address 0 instead of the write pointer. It reads the newest slot in the same cycle as a write, which must return the old data. On the change path it blocks the consumer while two registers change. A design that dropped or reordered records, or that changed a held record, shows a wrong index or value. A second change to the same register must give one fresh record and no repeats.

// File: rtl/jtt_pkg.sv
// Shared constants and types for the jump target trace buffer.
package jtt_pkg;
    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] PC_STEP  = 32'd4;
    localparam logic [XLEN-1:0] EMPTY_ENTRY = '1;
endpackage

// File: rtl/jtt_disc.sv
// Discontinuity detector: flags a valid PC that does not follow the previous
// valid PC by one instruction. Assumes pc_valid marks committed PCs only.
module jtt_disc
    import jtt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_valid,
    input  logic [XLEN-1:0] pc_value,
    output logic            cap_en,
    output logic [XLEN-1:0] last_pc
);
    logic [XLEN-1:0] prev_pc;

    // Break detection against the previous PC plus one step.
    always_comb begin
        cap_en = pc_valid && (pc_value != prev_pc + PC_STEP);
    end

    // Previous PC follows every valid PC, recorded or not.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_pc <= '0;
        else if (pc_valid) prev_pc <= pc_value;
    end

    assign last_pc = prev_pc;

    // R3: previous PC tracks each valid PC
    a_r3_prev_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |=> (prev_pc == $past(pc_value)));
endmodule

// File: rtl/jtt_ring.sv
// Circular store of break addresses with oldest-relative readout.
// Assumes DEPTH is a power of two so pointer arithmetic wraps naturally.
module jtt_ring
    import jtt_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [XLEN-1:0] cap_pc,
    input  logic            rd_en,
    input  logic            rd_random,
    input  logic            rd_restart,
    input  logic [AW-1:0]   rd_index,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_valid
);
    logic [XLEN-1:0] mem [DEPTH];
    logic [AW-1:0]   wptr;
    logic [AW-1:0]   cursor;
    logic [AW-1:0]   cur_eff;
    logic [AW-1:0]   rd_addr;

    // Read address counted from the oldest entry (the write pointer).
    always_comb begin
        cur_eff = rd_restart ? '0 : cursor;
        rd_addr = wptr + (rd_random ? rd_index : cur_eff);
    end

    // Entry storage and write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= EMPTY_ENTRY;
            wptr <= '0;
        end else if (cap_en) begin
            mem[wptr] <= cap_pc;
            wptr      <= wptr + 1'b1;
        end
    end

    // Step cursor and registered read port (sees pre-write contents).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor   <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[rd_addr];
            if (rd_en && !rd_random) cursor <= cur_eff + 1'b1;
            else cursor <= cur_eff;
        end
    end

    // R2: no break, no pointer movement
    a_r2_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(wptr));
    // R4: pointer wraps after the last slot
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && wptr == AW'(DEPTH-1)) |=> (wptr == '0));
    // R5: read data flagged one clock after the request
    a_r5_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: rtl/jtt_regscan.sv
// Register change scanner: walks the live register vector one index per
// clock, compares with a shadow copy and emits a record per difference.
// Assumes the consumer eventually raises ready; the scan waits meanwhile.
module jtt_regscan
    import jtt_pkg::*;
#(
    parameter int NREGS = 35,
    parameter int IW    = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREGS*XLEN-1:0] live,
    input  logic [XLEN-1:0]       cur_pc,
    input  logic                  out_ready,
    output logic                  out_valid,
    output logic [XLEN-1:0]       out_pc,
    output logic [IW-1:0]         out_idx,
    output logic [XLEN-1:0]       out_val
);
    logic [XLEN-1:0] shadow [NREGS];
    logic [IW-1:0]   scan_idx;
    logic [XLEN-1:0] live_cur;
    logic            advance;

    // Select the live value under inspection and decide whether to move on.
    always_comb begin
        live_cur = live[int'(scan_idx)*XLEN +: XLEN];
        advance  = !out_valid || out_ready;
    end

    // Scan index, shadow update and output record register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) shadow[i] <= '0;
            scan_idx  <= '0;
            out_valid <= 1'b0;
            out_pc    <= '0;
            out_idx   <= '0;
            out_val   <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (advance) begin
                if (live_cur != shadow[scan_idx]) begin
                    out_valid        <= 1'b1;
                    out_pc           <= cur_pc;
                    out_idx          <= scan_idx;
                    out_val          <= live_cur;
                    shadow[scan_idx] <= live_cur;
                end
                scan_idx <= (scan_idx == IW'(NREGS-1)) ? '0 : scan_idx + 1'b1;
            end
        end
    end

    // R9: a held record does not move
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) &&
                                       $stable(out_val) && $stable(out_pc)));
    // R10: the scan halts while blocked
    a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(scan_idx));
    // R8: reported index is a real register
    a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx < IW'(NREGS)));
endmodule

// File: rtl/jtt_top.sv
// Jump target trace buffer top: break detector, ring store and register
// change scanner. Change records carry the most recent valid PC.
module jtt_top
    import jtt_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NREGS = 35,
    parameter int AW    = $clog2(DEPTH),
    parameter int IW    = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pc_valid,
    input  logic [XLEN-1:0]       pc_value,
    input  logic                  rd_en,
    input  logic                  rd_random,
    input  logic                  rd_restart,
    input  logic [AW-1:0]         rd_index,
    output logic [XLEN-1:0]       rd_data,
    output logic                  rd_valid,
    input  logic [NREGS*XLEN-1:0] regs_live,
    output logic                  chg_valid,
    input  logic                  chg_ready,
    output logic [XLEN-1:0]       chg_pc,
    output logic [IW-1:0]         chg_idx,
    output logic [XLEN-1:0]       chg_value
);
    logic            cap_en;
    logic [XLEN-1:0] last_pc;

    jtt_disc u_disc (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc_value(pc_value),
        .cap_en(cap_en), .last_pc(last_pc)
    );

    jtt_ring #(.DEPTH(DEPTH), .AW(AW)) u_ring (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_pc(pc_value),
        .rd_en(rd_en), .rd_random(rd_random), .rd_restart(rd_restart),
        .rd_index(rd_index), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    jtt_regscan #(.NREGS(NREGS), .IW(IW)) u_scan (
        .clk(clk), .rst_n(rst_n), .live(regs_live), .cur_pc(last_pc),
        .out_ready(chg_ready), .out_valid(chg_valid), .out_pc(chg_pc),
        .out_idx(chg_idx), .out_val(chg_value)
    );
endmodule

// File: tb/jtt_top_tb.sv
module jtt_top_tb;
    localparam int DEPTH = 32;
    localparam int NREGS = 35;
    localparam int AW = 5;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pc_valid = 1'b0;
    logic [31:0] pc_value = '0;
    logic rd_en = 1'b0, rd_random = 1'b0, rd_restart = 1'b0;
    logic [AW-1:0] rd_index = '0;
    logic [31:0] rd_data;
    logic rd_valid;
    logic [NREGS*32-1:0] regs_live = '0;
    logic chg_valid;
    logic chg_ready = 1'b0;
    logic [31:0] chg_pc;
    logic [IW-1:0] chg_idx;
    logic [31:0] chg_value;

    int total = 0;
    int bad = 0;

    logic collect = 1'b0;
    int ncol = 0;
    logic [31:0] c_pc [16];
    logic [31:0] c_val [16];
    int c_idx [16];

    always #10 clk = ~clk;

    jtt_top u_dut (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc_value(pc_value),
        .rd_en(rd_en), .rd_random(rd_random), .rd_restart(rd_restart),
        .rd_index(rd_index), .rd_data(rd_data), .rd_valid(rd_valid),
        .regs_live(regs_live), .chg_valid(chg_valid), .chg_ready(chg_ready),
        .chg_pc(chg_pc), .chg_idx(chg_idx), .chg_value(chg_value)
    );

    // Record every handshake seen between edges.
    always @(negedge clk) begin
        if (collect && chg_valid && chg_ready && ncol < 16) begin
            c_pc[ncol]  <= chg_pc;
            c_val[ncol] <= chg_value;
            c_idx[ncol] <= int'(chg_idx);
            ncol <= ncol + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pc_valid = 0; rd_en = 0; rd_restart = 0; chg_ready = 0;
        regs_live = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_pc(input logic [31:0] v);
        pc_valid = 1'b1; pc_value = v;
        @(negedge clk);
        pc_valid = 1'b0;
    endtask

    task automatic read_step(input logic restart, output logic [31:0] d);
        rd_en = 1'b1; rd_random = 1'b0; rd_restart = restart;
        @(negedge clk);
        rd_en = 1'b0; rd_restart = 1'b0;
        d = rd_data;
    endtask

    task automatic read_idx(input int i, output logic [31:0] d);
        rd_en = 1'b1; rd_random = 1'b1; rd_index = AW'(i);
        @(negedge clk);
        rd_en = 1'b0; rd_random = 1'b0;
        d = rd_data;
    endtask

    task automatic set_reg(input int i, input logic [31:0] v);
        regs_live[i*32 +: 32] = v;
    endtask

    // Reset state of the ring and the change path.
    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        chk("R1 chg_valid after reset", {31'd0, chg_valid}, 32'd0);
        read_idx(0, d);  chk("R1 oldest entry", d, 32'hFFFF_FFFF);
        chk("R5 rd_valid pulse", {31'd0, rd_valid}, 32'd1);
        read_idx(31, d); chk("R1 newest entry", d, 32'hFFFF_FFFF);
        read_step(1'b0, d); chk("R1 first step read", d, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        chk("R5 rd_valid drops", {31'd0, rd_valid}, 32'd0);
    endtask

    // Break capture, previous-PC tracking and stepped readout.
    task automatic t_capture_step();
        logic [31:0] d;
        do_reset();
        push_pc(32'h4);
        read_idx(31, d); chk("R2 first PC 0x4 not captured", d, 32'hFFFF_FFFF);
        push_pc(32'h10);
        read_idx(31, d); chk("R2 jump captured", d, 32'h10);
        push_pc(32'h100); push_pc(32'h104); push_pc(32'h108);
        push_pc(32'h200); push_pc(32'h204); push_pc(32'h040);
        read_idx(30, d); chk("R3 0x108 not captured", d, 32'h200);
        for (int k = 0; k < 32; k++) begin
            read_step(1'b0, d);
            if (k == 0)  chk("R5 step oldest", d, 32'hFFFF_FFFF);
            if (k == 27) chk("R5 step 27", d, 32'hFFFF_FFFF);
            if (k == 28) chk("R5 step 28", d, 32'h10);
            if (k == 29) chk("R3 step 29", d, 32'h100);
            if (k == 30) chk("R5 step 30", d, 32'h200);
            if (k == 31) chk("R5 step newest", d, 32'h040);
        end
        for (int k = 0; k < 29; k++) read_step(1'b0, d);
        read_step(1'b1, d); chk("R5 restart reads oldest", d, 32'hFFFF_FFFF);
        for (int k = 0; k < 27; k++) read_step(1'b0, d);
        read_step(1'b0, d); chk("R5 cursor after restart", d, 32'h10);
    endtask

    // Wrap-around, indexed reads and a read colliding with a write.
    task automatic t_wrap_random();
        logic [31:0] d;
        do_reset();
        for (int k = 1; k <= 40; k++) push_pc(32'h1000 * k + 32'h10);
        read_idx(0, d);  chk("R4 oldest after wrap", d, 32'h9010);
        read_idx(5, d);  chk("R6 index 5", d, 32'hE010);
        read_idx(31, d); chk("R6 newest", d, 32'h28010);
        pc_valid = 1'b1; pc_value = 32'h7777_0000;
        rd_en = 1'b1; rd_random = 1'b1; rd_index = AW'(31);
        @(negedge clk);
        pc_valid = 1'b0; rd_en = 1'b0; rd_random = 1'b0;
        chk("R7 read sees pre-write contents", rd_data, 32'h28010);
        read_idx(31, d); chk("R7 write lands", d, 32'h7777_0000);
        read_idx(0, d);  chk("R4 oldest moved", d, 32'hA010);
    endtask

    // Change records for several registers, none for unchanged ones.
    task automatic t_reg_changes();
        int seen3, seen17, seen34;
        do_reset();
        push_pc(32'h1234);
        chg_ready = 1'b1;
        ncol = 0; collect = 1'b1;
        set_reg(3, 32'hA); set_reg(17, 32'hB); set_reg(34, 32'hC);
        repeat (NREGS + 3) @(negedge clk);
        chk("R10 records within one scan", ncol, 3);
        seen3 = 0; seen17 = 0; seen34 = 0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 record pc", c_pc[k], 32'h1234);
            if (c_idx[k] == 3)  begin seen3++;  chk("R8 reg3 value", c_val[k], 32'hA); end
            if (c_idx[k] == 17) begin seen17++; chk("R8 reg17 value", c_val[k], 32'hB); end
            if (c_idx[k] == 34) begin seen34++; chk("R8 EPC value", c_val[k], 32'hC); end
        end
        chk("R8 each reg once", seen3 + seen17 + seen34, 3);
        repeat (NREGS + 5) @(negedge clk);
        chk("R8 unchanged gives no record", ncol, 3);
        push_pc(32'h5000);
        set_reg(3, 32'hD);
        repeat (NREGS + 3) @(negedge clk);
        chk("R8 second change count", ncol, 4);
        chk("R8 second change idx", c_idx[3], 3);
        chk("R8 second change value", c_val[3], 32'hD);
        chk("R8 second change pc", c_pc[3], 32'h5000);
        collect = 1'b0;
    endtask

    // Backpressure: held record is stable, later change is not dropped.
    task automatic t_stall();
        do_reset();
        push_pc(32'h800);
        chg_ready = 1'b0;
        set_reg(5, 32'h5555);
        repeat (NREGS + 3) @(negedge clk);
        chk("R9 record waits", {31'd0, chg_valid}, 32'd1);
        chk("R9 held idx", {26'd0, chg_idx}, 32'd5);
        set_reg(6, 32'h6666);
        set_reg(5, 32'h9999);
        repeat (NREGS + 3) @(negedge clk);
        chk("R9 idx stable", {26'd0, chg_idx}, 32'd5);
        chk("R9 value stable", chg_value, 32'h5555);
        ncol = 0; collect = 1'b1; chg_ready = 1'b1;
        repeat (NREGS + 4) @(negedge clk);
        collect = 1'b0;
        chk("R9 record count", ncol, 3);
        chk("R9 first idx", c_idx[0], 5);
        chk("R9 first value", c_val[0], 32'h5555);
        chk("R9 next idx not dropped", c_idx[1], 6);
        chk("R9 next value", c_val[1], 32'h6666);
        chk("R9 rescan idx", c_idx[2], 5);
        chk("R9 rescan value", c_val[2], 32'h9999);
    endtask

    initial begin
        t_reset_state();
        t_capture_step();
        t_wrap_random();
        t_reg_changes();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule